// File: doc/BRIEF.md
# Serial Byte Transmitter with Build-Time Parity

This block turns single bytes into asynchronous serial frames on a line that rests at logic high. A client presents a byte and raises a send strobe for one clock cycle. If the transmitter is idle it captures the byte, raises its busy flag and shifts the frame out. Each bit occupies one bit cell, and a bit cell is a whole number of system clocks derived from the clock frequency and baud rate parameters. Send strobes that arrive while a frame is in flight are dropped.

A frame has a low start bit, then the eight data bits with the least significant first, then an optional parity bit, then a single high stop bit. The parity choice is fixed when the block is built. It can be no parity bit at all, even, odd, a constant one, or a constant zero. The bit-cell divider is inside the block, so the only external timing reference is the system clock.

Top module: `ser_tx`

## Requirements
- R1: After reset, and whenever busy is low, `txd` is 1 and `busy` is 0. `busy` is 0 on the first clock after reset.
- R2: A send accepted at a rising edge (`send`=1 while `busy`=0) drives `txd` low for exactly one bit cell, starting in the cycle after that edge. A bit cell is DIV = CLK_HZ/BAUD clocks.
- R3: The next eight bit cells carry `data[0]` through `data[7]` in that order. Each is exactly one bit cell long.
- R4: With PARITY set to PAR_EVEN, PAR_ODD, PAR_MARK or PAR_SPACE, a tenth cell follows the data. For PAR_EVEN it makes the ones in data plus this bit even. For PAR_ODD it makes them odd. PAR_MARK sends 1 and PAR_SPACE sends 0. PAR_NONE has no tenth cell.
- R5: The last cell of the frame is a high stop bit lasting one full bit cell. A frame is 10 cells long with PAR_NONE and 11 cells long otherwise.
- R6: `busy` goes high in the cycle after an accepted send. It stays high for exactly (frame cells × DIV) cycles, then goes low.
- R7: A send strobe while `busy` is high is ignored. The frame in progress keeps its data and its timing.
- R8: A send strobe raised in the first cycle that `busy` is low is accepted. The next frame then starts immediately, with no extra idle cell.
- R9: `rst` is sampled at the clock edge. Asserting it mid-frame returns the block to idle (`txd`=1, `busy`=0) on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| send | input | 1 | One-cycle request to transmit `data` |
| data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial output, idle high, registered |
| busy | output | 1 | Frame in progress; requests are refused |

## Verification
The bench builds five copies, one per parity mode, with an 8-clock bit cell. It sends all 256 byte values and compares the line against the computed frame on every clock. Any bit-order reversal, wrong parity sense, or cell off by one clock therefore shows up as a mismatch at the cell edge. A stray strobe with the inverted byte is injected into half of the frames. A design that reloads or restarts while busy would then emit the inverted bits or stretch the frame. Back-to-back frames check that a request in the first idle cycle is accepted and that the stop bit is not cut short. A reset in the middle of a frame checks that the line returns high at once.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  localparam int unsigned DATA_W = 8;

  function automatic int unsigned frame_cells(par_mode_e m);
    return (m == PAR_NONE) ? DATA_W + 2 : DATA_W + 3;
  endfunction
endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int unsigned DIV = 434
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = en && (cnt_q == LAST);

  // R2: divider never leaves its 0..DIV-1 range
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/ser_tx_parity.sv
module ser_tx_parity #(
  parameter ser_tx_pkg::par_mode_e PARITY = ser_tx_pkg::PAR_NONE
) (
  input  logic [ser_tx_pkg::DATA_W-1:0] data,
  output logic                          par
);
  import ser_tx_pkg::*;

  generate
    if (PARITY == PAR_EVEN) begin : g_even
      assign par = ^data;
    end else if (PARITY == PAR_ODD) begin : g_odd
      assign par = ~^data;
    end else if (PARITY == PAR_MARK) begin : g_mark
      assign par = 1'b1;
    end else begin : g_space_none
      assign par = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ser_tx.sv
module ser_tx #(
  parameter int unsigned           CLK_HZ = 50_000_000,
  parameter int unsigned           BAUD   = 115_200,
  parameter ser_tx_pkg::par_mode_e PARITY = ser_tx_pkg::PAR_NONE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       send,
  input  logic [7:0] data,
  output logic       txd,
  output logic       busy
);
  import ser_tx_pkg::*;

  localparam int unsigned DIV = CLK_HZ / BAUD;
  localparam int unsigned NB  = frame_cells(PARITY);
  localparam int unsigned KW  = $clog2(NB + 1);
  localparam logic [KW-1:0] LAST_CELL = KW'(NB - 1);

  logic          busy_q, txd_q, tick, par, accept;
  logic [NB-1:0] frame, sh_q;
  logic [KW-1:0] cell_q;

  assign accept = send && !busy_q;

  ser_tx_baud #(.DIV(DIV)) u_baud (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .en  (busy_q),
    .tick(tick)
  );

  ser_tx_parity #(.PARITY(PARITY)) u_par (
    .data(data),
    .par (par)
  );

  generate
    if (PARITY == PAR_NONE) begin : g_frame_np
      assign frame = {1'b1, data, 1'b0};
    end else begin : g_frame_p
      assign frame = {1'b1, par, data, 1'b0};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      sh_q   <= '1;
      cell_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      txd_q  <= frame[0];
      sh_q   <= frame;
      cell_q <= '0;
    end else if (tick) begin
      if (cell_q == LAST_CELL) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
        sh_q   <= '1;
        cell_q <= '0;
      end else begin
        txd_q  <= sh_q[1];
        sh_q   <= {1'b1, sh_q[NB-1:1]};
        cell_q <= cell_q + 1'b1;
      end
    end
  end

  assign txd  = txd_q;
  assign busy = busy_q;

  // R1: line rests high whenever no frame is in flight
  p_idle_line_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);

  // R6: an accepted request raises busy on the next cycle
  p_busy_rise_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy_q);

  // R2: the first cell after acceptance is the low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !txd_q);

  // R5: the final cell being closed out carries a high stop bit
  p_stop_high_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cell_q == LAST_CELL) |-> txd_q);

  // R7: a request during a frame leaves the frame state alone
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && send && !tick) |=> ($stable(sh_q) && $stable(cell_q) && busy_q));
endmodule

// File: tb/ser_tx_bench.sv
`timescale 1ns/1ps
module ser_tx_bench;
  import ser_tx_pkg::*;

  localparam int unsigned DIV   = 8;
  localparam int unsigned NMODE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic send = 1'b0;
  logic [7:0] data = 8'h00;
  logic [NMODE-1:0] txd, busy;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  generate
    for (genvar m = 0; m < NMODE; m++) begin : g_dut
      ser_tx #(.CLK_HZ(DIV * 1000), .BAUD(1000), .PARITY(par_mode_e'(m))) u_ser_tx (
        .clk (clk),
        .rst (rst),
        .send(send),
        .data(data),
        .txd (txd[m]),
        .busy(busy[m])
      );
    end
  endgenerate

  function automatic int cells_of(int m);
    return (m == 0) ? 10 : 11;
  endfunction

  // expected line value in cycle n after acceptance (n >= 1)
  function automatic logic exp_line(int m, logic [7:0] b, int n);
    int c;
    c = (n - 1) / DIV;
    if (c >= cells_of(m)) return 1'b1;
    if (c == 0) return 1'b0;
    if (c <= 8) return b[c-1];
    if (c == 9 && m != 0) begin
      case (m)
        1: return ^b;
        2: return ~^b;
        3: return 1'b1;
        default: return 1'b0;
      endcase
    end
    return 1'b1;
  endfunction

  function automatic string tag_of(int m, int n);
    int c;
    c = (n - 1) / DIV;
    if (c >= cells_of(m)) return "R1";
    if (c == 0) return "R2";
    if (c <= 8) return "R3";
    if (c == 9 && m != 0) return "R4";
    return "R5";
  endfunction

  task automatic chk(string req, string what, logic act, logic exp, int m, int n);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s mode=%0d cyc=%0d actual=%b expected=%b", req, what, m, n, act, exp);
    end
  endtask

  // one frame on all five copies; inject = stray strobe mid-frame (R7)
  task automatic run_frame(logic [7:0] b, bit inject);
    @(negedge clk);
    data = b;
    send = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= 11 * DIV + 1; n++) begin
      @(negedge clk);
      for (int m = 0; m < NMODE; m++) begin
        chk(inject ? "R7" : tag_of(m, n), "txd", txd[m], exp_line(m, b, n), m, n);
        chk(inject ? "R7" : "R6", "busy", busy[m], (n <= cells_of(m) * DIV), m, n);
      end
      if (n == 1) send = 1'b0;
      if (inject && n == 3 * DIV + 2) begin
        data = ~b;
        send = 1'b1;
      end
      if (inject && n == 3 * DIV + 3) send = 1'b0;
    end
  endtask

  // back-to-back frames on the no-parity copy (R8)
  task automatic run_chain(logic [7:0] a, logic [7:0] b);
    int last;
    last = 10 * DIV + 1;
    @(negedge clk);
    data = a;
    send = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= last; n++) begin
      @(negedge clk);
      if (n == 1) send = 1'b0;
      chk("R8", "txd", txd[0], exp_line(0, a, n), 0, n);
      chk("R8", "busy", busy[0], (n <= 10 * DIV), 0, n);
    end
    data = b;
    send = 1'b1;
    @(posedge clk);
    for (int n = 1; n <= last; n++) begin
      @(negedge clk);
      if (n == 1) send = 1'b0;
      chk("R8", "txd", txd[0], exp_line(0, b, n), 0, n);
      chk("R8", "busy", busy[0], (n <= 10 * DIV), 0, n);
    end
    repeat (12 * DIV) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < NMODE; m++) begin
      chk("R1", "reset txd", txd[m], 1'b1, m, 0);
      chk("R1", "reset busy", busy[m], 1'b0, m, 0);
    end

    for (int v = 0; v < 256; v++) run_frame(8'(v), v[0]);

    run_chain(8'hA5, 8'h3C);
    run_chain(8'h00, 8'hFF);

    // R9: reset in the middle of a frame
    @(negedge clk);
    data = 8'h00;
    send = 1'b1;
    @(negedge clk);
    send = 1'b0;
    repeat (4 * DIV) @(negedge clk);
    for (int m = 0; m < NMODE; m++)
      chk("R9", "busy before reset", busy[m], 1'b1, m, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int m = 0; m < NMODE; m++) begin
      chk("R9", "txd after reset", txd[m], 1'b1, m, 0);
      chk("R9", "busy after reset", busy[m], 1'b0, m, 0);
    end
    run_frame(8'h96, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule